// File: doc/BRIEF.md
# Page-Mode Burst Read Sequencer

This block sits between a processor-side request port and a simple memory that returns a 64-bit word for any word address without delay. It accepts one read request at a time, either a single word or a burst of four words at consecutive word addresses. Each word, called a beat, is handed back with a one-cycle ready pulse after a configurable number of bus cycles. The first beat of a burst is slow and the later ones are fast, giving the familiar x-y-y-y read shape.

The sequencer remembers which memory page was opened last. A page is every address bit above the column field. Any beat whose address falls in a page other than the open one pays an extra, configurable number of wait states while that page is selected. When the fast-beat mode is switched off, every beat costs as much as a first beat, which turns 5-3-3-3 into 5-5-5-5. The three timing values and the mode are sampled together with the request, so the host can change them between transactions at will.

Top module: `page_burst_seq`

## Requirements
- R1: After reset `req_ready` is 1 and `beat_valid` and `beat_last` are 0. No page counts as open, so the first beat after reset is always a page miss.
- R2: A request is accepted on a rising edge where `req_valid` is 1 and `req_ready` is 1. `req_ready` is 0 from the cycle after acceptance until the cycle of the final ready pulse, and is 1 again in that cycle. A request presented while `req_ready` is 0 is ignored and creates no beats.
- R3: A burst request (`req_burst`=1) yields exactly four ready pulses. They are for word addresses A, A+1, A+2 and A+3 (modulo 2^AW), where A is the accepted `req_addr`. `beat_last` is 1 only with the fourth pulse.
- R4: A single request (`req_burst`=0) yields exactly one ready pulse, with `beat_last`=1.
- R5: The first ready pulse appears in the cycle that follows the rising edge lying `cfg_first` edges after the acceptance edge, plus any miss penalty. A value of 0 acts as 1.
- R6: With `cfg_fast_beats`=1, each later beat of a burst arrives `cfg_next` edges after the previous pulse (0 acts as 1), plus any miss penalty.
- R7: With `cfg_fast_beats`=0, each later beat of a burst arrives `cfg_first` edges after the previous pulse (0 acts as 1), plus any miss penalty.
- R8: The page of a word address is its bits [AW-1:COLW]. A beat whose page differs from the open page, or that comes while no page is open, takes `cfg_miss` extra edges. Each beat's page becomes the open page.
- R9: A burst that runs past the end of a page pays the miss penalty on the first beat in the new page. The beats after it in that same page do not pay it.
- R10: `cfg_first`, `cfg_next`, `cfg_miss` and `cfg_fast_beats` are sampled only at acceptance. Changing them during a transaction does not alter its timing.
- R11: `beat_data` carries the 64-bit `mem_rdata` returned for that beat's address while `mem_addr` presented it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_burst | input | 1 | 1 = four-beat burst, 0 = single word |
| req_addr | input | AW | Starting word address |
| cfg_first | input | CW | Edges for a full-latency beat |
| cfg_next | input | CW | Edges for a fast burst beat |
| cfg_miss | input | CW | Extra edges on a page miss |
| cfg_fast_beats | input | 1 | 1 = later burst beats use `cfg_next` |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| mem_addr | output | AW | Word address presented to memory |
| mem_rdata | input | DW | Memory read data for `mem_addr` |
| beat_valid | output | 1 | One-cycle ready pulse for a beat |
| beat_last | output | 1 | Marks the final beat of a transaction |
| beat_data | output | DW | Data of the current beat |

## Verification
The embedded properties assume that `mem_rdata` depends only on `mem_addr`. They also assume that reset is held for at least one edge before any request. The bench models the memory as a pure function of the address, so the first assumption always holds. It keeps `req_valid` low during reset. While a transaction is in flight it toggles `req_valid`, `req_addr` and the configuration inputs at random, to exercise the ignored-request and sampling rules. It lowers `req_valid` in the cycle where it sees the final pulse, so that noise is never taken as a real request.

// File: rtl/page_burst_seq.sv
module page_burst_seq #(
  parameter int AW   = 16,
  parameter int DW   = 64,
  parameter int COLW = 6,
  parameter int CW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_burst,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] cfg_first,
  input  logic [CW-1:0] cfg_next,
  input  logic [CW-1:0] cfg_miss,
  input  logic          cfg_fast_beats,
  output logic          req_ready,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          beat_valid,
  output logic          beat_last,
  output logic [DW-1:0] beat_data
);
  localparam int PW = AW - COLW;
  localparam int TW = CW + 2;

  logic          busy;
  logic [1:0]    left;
  logic [AW-1:0] addr_q;
  logic [PW-1:0] open_pg;
  logic          pg_vld;
  logic [CW-1:0] x_q, y_q, pen_q;
  logic          fast_q;
  logic [TW-1:0] cnt;

  function automatic logic [TW-1:0] beat_cost(input logic [CW-1:0] base,
                                               input logic miss,
                                               input logic [CW-1:0] pen);
    logic [TW-1:0] b;
    b = (base == '0) ? TW'(1) : TW'(base);
    return b + (miss ? TW'(pen) : TW'(0));
  endfunction

  wire           accept   = req_valid && !busy;
  wire           done     = busy && (cnt == TW'(1));
  wire [AW-1:0]  nxt_addr = addr_q + AW'(1);
  wire [PW-1:0]  req_pg   = req_addr[AW-1:COLW];
  wire [PW-1:0]  nxt_pg   = nxt_addr[AW-1:COLW];
  wire           req_miss = !pg_vld || (req_pg != open_pg);
  wire           nxt_miss = nxt_pg != open_pg;

  assign req_ready = !busy;
  assign mem_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      left       <= '0;
      addr_q     <= '0;
      open_pg    <= '0;
      pg_vld     <= 1'b0;
      x_q        <= '0;
      y_q        <= '0;
      pen_q      <= '0;
      fast_q     <= 1'b0;
      cnt        <= '0;
      beat_valid <= 1'b0;
      beat_last  <= 1'b0;
      beat_data  <= '0;
    end else begin
      beat_valid <= 1'b0;
      beat_last  <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        left    <= req_burst ? 2'd3 : 2'd0;
        addr_q  <= req_addr;
        open_pg <= req_pg;
        pg_vld  <= 1'b1;
        x_q     <= cfg_first;
        y_q     <= cfg_next;
        pen_q   <= cfg_miss;
        fast_q  <= cfg_fast_beats;
        cnt     <= beat_cost(cfg_first, req_miss, cfg_miss);
      end else if (done) begin
        beat_valid <= 1'b1;
        beat_data  <= mem_rdata;
        if (left == 2'd0) begin
          busy      <= 1'b0;
          beat_last <= 1'b1;
        end else begin
          left    <= left - 2'd1;
          addr_q  <= nxt_addr;
          open_pg <= nxt_pg;
          cnt     <= beat_cost(fast_q ? y_q : x_q, nxt_miss, pen_q);
        end
      end else if (busy) begin
        cnt <= cnt - TW'(1);
      end
    end
  end

  // R3
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R2
  mid_beat_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |-> !req_ready);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (beat_valid || $stable(mem_addr)));
endmodule

// File: tb/page_burst_seq_bench.sv
module page_burst_seq_bench;
  localparam int AW = 16, DW = 64, COLW = 6, CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_burst = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] cfg_first = '0, cfg_next = '0, cfg_miss = '0;
  logic          cfg_fast_beats = 1'b0;
  logic          req_ready, beat_valid, beat_last;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata, beat_data;

  int errors = 0, checks = 0, cycles = 0;
  logic [AW-COLW-1:0] m_pg = '0;
  logic m_vld = 1'b0;

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return {16'hC0DE, a, ~a, a ^ 16'h5A5A};
  endfunction

  function automatic int costf(input logic [CW-1:0] base, input logic miss, input logic [CW-1:0] pen);
    return ((base == 0) ? 1 : int'(base)) + (miss ? int'(pen) : 0);
  endfunction

  assign mem_rdata = memf(mem_addr);

  page_burst_seq #(.AW(AW), .DW(DW), .COLW(COLW), .CW(CW)) u_page_burst_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_burst(req_burst),
    .req_addr(req_addr), .cfg_first(cfg_first), .cfg_next(cfg_next),
    .cfg_miss(cfg_miss), .cfg_fast_beats(cfg_fast_beats), .req_ready(req_ready),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .beat_valid(beat_valid),
    .beat_last(beat_last), .beat_data(beat_data));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic noise();
    req_valid      = 1'($urandom);
    req_addr       = AW'($urandom);
    req_burst      = 1'($urandom);
    cfg_first      = CW'($urandom);
    cfg_next       = CW'($urandom);
    cfg_miss       = CW'($urandom);
    cfg_fast_beats = 1'($urandom);
  endtask

  task automatic run_txn(input logic [AW-1:0] a, input bit burst, input logic [CW-1:0] x,
                         input logic [CW-1:0] y, input logic [CW-1:0] p, input bit fast,
                         input bit noisy);
    int nb;
    logic [AW-1:0] cur;
    logic miss;
    int exp_gap;
    int k;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_burst = burst;
    cfg_first = x; cfg_next = y; cfg_miss = p; cfg_fast_beats = fast;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
    if (noisy) noise();
    nb = burst ? 4 : 1;
    cur = a;
    for (int b = 0; b < nb; b++) begin
      if (b == 0) begin
        miss = !m_vld || (a[AW-1:COLW] != m_pg);
        exp_gap = costf(x, miss, p);
      end else begin
        cur = cur + AW'(1);
        miss = cur[AW-1:COLW] != m_pg;
        exp_gap = costf(fast ? y : x, miss, p);
      end
      m_pg = cur[AW-1:COLW];
      m_vld = 1'b1;
      k = 0;
      do begin
        @(posedge clk);
        k++;
        @(negedge clk);
        if (!beat_valid && noisy) noise();
      end while (!beat_valid && k < 40);
      if (beat_last) req_valid = 1'b0;
      if (b == 0) chk(k == exp_gap, "R5/R8 first beat gap", k, exp_gap);
      else if (fast) chk(k == exp_gap, "R6/R9 fast beat gap", k, exp_gap);
      else chk(k == exp_gap, "R7/R9 slow beat gap", k, exp_gap);
      chk(beat_data == memf(cur), "R3/R11 beat data", beat_data, memf(cur));
      chk(beat_last == (b == nb - 1), burst ? "R3 last flag" : "R4 last flag", beat_last, b == nb - 1);
      chk(req_ready == (b == nb - 1), "R2 ready at beat", req_ready, b == nb - 1);
      if (noisy && b < nb - 1) noise();
    end
    req_valid = 1'b0;
    if (noisy) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(!beat_valid && req_ready, "R2 ignored request made no beat", beat_valid, 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(beat_valid == 1'b0 && beat_last == 1'b0, "R1 reset outputs", beat_valid, 0);
    rst_n = 1'b1;
    // R1, R5, R6, R8: first access after reset misses, 5-3-3-3 plus penalty
    run_txn(16'h0100, 1'b1, 4'd5, 4'd3, 4'd2, 1'b1, 1'b0);
    // R6: same page, plain 5-3-3-3
    run_txn(16'h0104, 1'b1, 4'd5, 4'd3, 4'd2, 1'b1, 1'b0);
    // R7: fast mode off gives 5-5-5-5
    run_txn(16'h0108, 1'b1, 4'd5, 4'd3, 4'd2, 1'b0, 1'b0);
    // R4: single access, other page
    run_txn(16'h0200, 1'b0, 4'd5, 4'd3, 4'd3, 1'b1, 1'b0);
    // R5, R6: zero config acts as one
    run_txn(16'h0201, 1'b1, 4'd0, 4'd0, 4'd0, 1'b1, 1'b0);
    // R9: burst crosses page boundary at third beat
    run_txn(16'h023E, 1'b1, 4'd5, 4'd2, 4'd4, 1'b1, 1'b0);
    // R9: wrap of address space
    run_txn(16'hFFFF, 1'b1, 4'd3, 4'd1, 4'd2, 1'b1, 1'b0);
    // R10, R2: config and request noise during a burst
    run_txn(16'h0300, 1'b1, 4'd6, 4'd2, 4'd3, 1'b1, 1'b1);
    for (int t = 0; t < 250; t++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      if ($urandom % 3 == 0) a = {m_pg, COLW'($urandom)};
      run_txn(a, 1'($urandom), CW'($urandom), CW'($urandom), CW'($urandom),
              1'($urandom), ($urandom % 2) == 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule